// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block stands between a single requester and a DRAM array built as a square cell matrix of 16K rows, each 16K bits wide. Every row has to be refreshed at least once in each 50 ms retention window, and one row refresh holds the array for 100 ns. The scheduler does not refresh the whole array in one burst. It raises one refresh demand per fixed interval of clock cycles, which by default spreads the 16384 row refreshes evenly over the window. It then places each refresh between the user accesses.

Pending refresh demands are counted up to a small ceiling. While any demand is pending, the array is handed to refresh as soon as it falls idle, and no new user access is granted. A user access that has already started always runs to its end. Refreshes go to the rows in ascending order through a wrapping row counter. A running total of the cycles spent refreshing lets the consumed bandwidth be measured. With the default timing this is roughly 1.64 ms out of every 50 ms, or about 3.3 %.

The upstream side is a combinational request/grant pair with row, column and a write flag. The downstream side is a one-cycle command code with a row and a column address: 14 row bits, plus 11 column bits that pick one byte of a 2 KB row.

Top module: `refresh_sched`

## Requirements
- R1: During and right after reset, dram_cmd is 0 (no operation), req_grant and array_busy are 0, and pend_count, next_row and refresh_cycles are all 0.
- R2: The interval timer runs freely, with no gaps, and produces one refresh demand every TICK_CYCLES cycles. With no user traffic, consecutive refresh commands are exactly TICK_CYCLES cycles apart.
- R3: pend_count rises by one for each demand and falls by one for each issued refresh. It never goes above MAX_PEND. A demand that arrives while the count is at MAX_PEND and no refresh issues in that cycle is dropped.
- R4: A refresh is issued only in an idle cycle with pend_count non-zero. It shows dram_cmd = 3 for one cycle, with dram_row equal to next_row.
- R5: A user request is granted only in an idle cycle with pend_count zero. In that same cycle req_grant is 1, dram_cmd is 1 for a read or 2 for a write (req_write = 1), and dram_row and dram_col carry req_row and req_col.
- R6: An access that is in progress is never cut short, so a demand raised during it waits until the access ends. While pend_count is non-zero, req_grant stays 0.
- R7: After a refresh command, array_busy is 1 for exactly REF_CYCLES cycles. After a grant, array_busy is 1 for exactly ACC_CYCLES cycles. The array is idle for at least one cycle between operations.
- R8: next_row steps by one when each refresh completes and wraps from 2^ROW_W-1 back to 0.
- R9: refresh_cycles rises by one in each cycle the array spends refreshing, so it rises by REF_CYCLES per refresh and holds still otherwise.
- R10: When demands arrive faster than refreshes can be served, pend_count settles at MAX_PEND and a steady request is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | User access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column (byte) address of the request |
| req_grant | output | 1 | Request accepted this cycle |
| dram_cmd | output | 2 | 0 none, 1 read, 2 write, 3 refresh; one cycle per operation |
| dram_row | output | ROW_W | Row address for the command |
| dram_col | output | COL_W | Column address for the command |
| array_busy | output | 1 | Array occupied by an operation |
| pend_count | output | $clog2(MAX_PEND+1) | Refresh demands waiting |
| next_row | output | ROW_W | Row the next refresh will target |
| refresh_cycles | output | CYC_W | Total cycles spent refreshing |

## Verification
The main bench instance uses TICK_CYCLES = 40, REF_CYCLES = 5, ACC_CYCLES = 3, MAX_PEND = 4, ROW_W = 3 and COL_W = 4. With these values the row counter wraps after eight refreshes, and the exact demand phase can be predicted, so a grant placed two cycles before a demand shows the refresh being pushed back by the access. A second instance uses TICK_CYCLES = 4 against a five-cycle refresh. Demands then come in faster than they can be served, which brings the pending ceiling and the starvation of user requests within reach in a few hundred cycles.

// File: rtl/refsched_pkg.sv
// Shared types of the refresh scheduler.
// Assumes: the command code is decoded by the array side as given here.
package refsched_pkg;
    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_READ    = 2'd1,
        CMD_WRITE   = 2'd2,
        CMD_REFRESH = 2'd3
    } dram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_USER = 2'd1,
        ST_REF  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/refsched_timer.sv
// Free-running interval timer: pulses tick once every TICK_CYCLES cycles.
// Assumes: TICK_CYCLES >= 2; the count restarts from zero on reset.
module refsched_timer #(
    parameter int TICK_CYCLES = 305
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(TICK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refsched_pend.sv
// Pending-refresh counter: adds a demand per tick, removes one per issued
// refresh, and saturates at MAX_PEND.
// Assumes: take is raised only while the count is non-zero.
module refsched_pend #(
    parameter int MAX_PEND = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            take,
    output logic [$clog2(MAX_PEND+1)-1:0]   count,
    output logic                            nonzero
);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic [PEND_W:0] sum;
    logic [PEND_W-1:0] count_nxt;

    // Form count + tick - take and clamp to the ceiling.
    always_comb begin
        sum = {1'b0, count} + (PEND_W+1)'(tick) - (PEND_W+1)'(take);
        if (sum > (PEND_W+1)'(MAX_PEND)) count_nxt = PEND_W'(MAX_PEND);
        else                             count_nxt = sum[PEND_W-1:0];
    end

    // Register the pending count.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

    assign nonzero = (count != '0);

    p_pend_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PEND_W'(MAX_PEND));

    p_pend_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && count != PEND_W'(MAX_PEND)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/refsched_rowctr.sv
// Refresh row pointer: moves to the next row when a refresh completes and
// wraps at the top of the row space.
// Assumes: the row space is a power of two (2^ROW_W rows).
module refsched_rowctr #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    // Advance the pointer after each completed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end

    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> (row == ROW_W'($past(row) + 1'b1)));
endmodule

// File: rtl/refsched_arb.sv
// Array arbiter: from an idle array it starts a refresh when one is pending,
// otherwise it grants a user request. It then holds the array for the
// duration of the operation.
// Assumes: operations are never aborted; REF_CYCLES and ACC_CYCLES >= 1.
module refsched_arb
    import refsched_pkg::*;
#(
    parameter int ROW_W      = 14,
    parameter int COL_W      = 11,
    parameter int REF_CYCLES = 10,
    parameter int ACC_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             pend_nonzero,
    input  logic [ROW_W-1:0] ref_row,
    output logic             grant,
    output dram_cmd_e        cmd,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             busy,
    output logic             ref_active,
    output logic             ref_issue,
    output logic             ref_done
);
    localparam int MAX_DUR = (REF_CYCLES > ACC_CYCLES) ? REF_CYCLES : ACC_CYCLES;
    localparam int DUR_W   = $clog2(MAX_DUR + 1);

    arb_state_e       state;
    logic [DUR_W-1:0] rem;

    // Choose this cycle's command from an idle array.
    always_comb begin
        grant     = 1'b0;
        ref_issue = 1'b0;
        cmd       = CMD_NOP;
        cmd_row   = '0;
        cmd_col   = '0;
        if (state == ST_IDLE) begin
            if (pend_nonzero) begin
                ref_issue = 1'b1;
                cmd       = CMD_REFRESH;
                cmd_row   = ref_row;
            end else if (req_valid) begin
                grant   = 1'b1;
                cmd     = req_write ? CMD_WRITE : CMD_READ;
                cmd_row = req_row;
                cmd_col = req_col;
            end
        end
    end

    assign busy       = (state != ST_IDLE);
    assign ref_active = (state == ST_REF);
    assign ref_done   = (state == ST_REF) && (rem == '0);

    // Hold the array for the operation length, then return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_issue) begin
                        state <= ST_REF;
                        rem   <= DUR_W'(REF_CYCLES - 1);
                    end else if (grant) begin
                        state <= ST_USER;
                        rem   <= DUR_W'(ACC_CYCLES - 1);
                    end
                end
                default: begin
                    if (rem == '0) state <= ST_IDLE;
                    else           rem   <= rem - 1'b1;
                end
            endcase
        end
    end

    p_no_grant_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !grant);

    p_ref_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue |=> (busy && ref_active));

    p_user_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (busy && !ref_active));
endmodule

// File: rtl/refresh_sched.sv
// DRAM row refresh scheduler top: interval timer, pending counter, row
// pointer and arbiter, plus the total of cycles spent refreshing.
// Assumes: one requester; commands are single-cycle pulses decoded by the array.
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter int COL_W       = 11,
    parameter int TICK_CYCLES = 305,
    parameter int REF_CYCLES  = 10,
    parameter int ACC_CYCLES  = 4,
    parameter int MAX_PEND    = 8,
    parameter int CYC_W       = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ROW_W-1:0]              req_row,
    input  logic [COL_W-1:0]              req_col,
    output logic                          req_grant,
    output logic [1:0]                    dram_cmd,
    output logic [ROW_W-1:0]              dram_row,
    output logic [COL_W-1:0]              dram_col,
    output logic                          array_busy,
    output logic [$clog2(MAX_PEND+1)-1:0] pend_count,
    output logic [ROW_W-1:0]              next_row,
    output logic [CYC_W-1:0]              refresh_cycles
);
    logic      tick;
    logic      pend_nz;
    logic      ref_issue;
    logic      ref_done;
    logic      ref_active;
    dram_cmd_e cmd;

    refsched_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    refsched_pend #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .take    (ref_issue),
        .count   (pend_count),
        .nonzero (pend_nz)
    );

    refsched_rowctr #(.ROW_W(ROW_W)) u_rowctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_done),
        .row   (next_row)
    );

    refsched_arb #(
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .REF_CYCLES (REF_CYCLES),
        .ACC_CYCLES (ACC_CYCLES)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_row      (req_row),
        .req_col      (req_col),
        .pend_nonzero (pend_nz),
        .ref_row      (next_row),
        .grant        (req_grant),
        .cmd          (cmd),
        .cmd_row      (dram_row),
        .cmd_col      (dram_col),
        .busy         (array_busy),
        .ref_active   (ref_active),
        .ref_issue    (ref_issue),
        .ref_done     (ref_done)
    );

    assign dram_cmd = cmd;

    // Accumulate every cycle the array spends refreshing.
    always_ff @(posedge clk) begin
        if (!rst_n)          refresh_cycles <= '0;
        else if (ref_active) refresh_cycles <= refresh_cycles + 1'b1;
    end

    p_cost_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ref_active) |-> $stable(refresh_cycles));

    p_grant_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> (pend_count == '0));

    p_ref_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 2'd3) |-> (dram_row == next_row && !array_busy));
endmodule

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int ROW_W = 3;
    localparam int COL_W = 4;
    localparam int TICK  = 40;
    localparam int REFC  = 5;
    localparam int ACCC  = 3;
    localparam int MAXP  = 4;
    localparam int PW    = $clog2(MAXP + 1);

    // Vector: {write, row[2:0], col[3:0]}
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0_000_0000, 8'b1_111_1111, 8'b0_101_1010,
        8'b1_010_0101, 8'b1_001_0011, 8'b0_110_1100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_grant;
    logic [1:0] dram_cmd;
    logic [ROW_W-1:0] dram_row;
    logic [COL_W-1:0] dram_col;
    logic array_busy;
    logic [PW-1:0] pend_count;
    logic [ROW_W-1:0] next_row;
    logic [15:0] refresh_cycles;

    logic s_grant;
    logic [1:0] s_cmd;
    logic [ROW_W-1:0] s_row;
    logic [COL_W-1:0] s_col;
    logic s_busy;
    logic [PW-1:0] s_pend;
    logic [ROW_W-1:0] s_next;
    logic [15:0] s_cyc;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_sched #(
        .ROW_W(ROW_W), .COL_W(COL_W), .TICK_CYCLES(TICK), .REF_CYCLES(REFC),
        .ACC_CYCLES(ACCC), .MAX_PEND(MAXP), .CYC_W(16)
    ) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_grant(req_grant),
        .dram_cmd(dram_cmd), .dram_row(dram_row), .dram_col(dram_col),
        .array_busy(array_busy), .pend_count(pend_count), .next_row(next_row),
        .refresh_cycles(refresh_cycles)
    );

    refresh_sched #(
        .ROW_W(ROW_W), .COL_W(COL_W), .TICK_CYCLES(4), .REF_CYCLES(REFC),
        .ACC_CYCLES(ACCC), .MAX_PEND(MAXP), .CYC_W(16)
    ) u_refresh_sched_sat (
        .clk(clk), .rst_n(rst_n), .req_valid(rst_n), .req_write(1'b0),
        .req_row('0), .req_col('0), .req_grant(s_grant),
        .dram_cmd(s_cmd), .dram_row(s_row), .dram_col(s_col),
        .array_busy(s_busy), .pend_count(s_pend), .next_row(s_next),
        .refresh_cycles(s_cyc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(output int at);
        int guard = 0;
        @(negedge clk);
        #1;
        while (dram_cmd != 2'd3 && guard < 1000) begin
            @(negedge clk);
            #1;
            guard++;
        end
        at = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int prev;
        int t;
        int n;
        int tref;
        int smax;
        bit sgrant;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(dram_cmd == 2'd0 && !req_grant && !array_busy, "R1 cmd/grant/busy", dram_cmd, 0);
        chk(pend_count == 0 && next_row == 0 && refresh_cycles == 0, "R1 counters",
            pend_count + next_row + refresh_cycles, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dram_cmd == 2'd0 && !array_busy && pend_count == 0, "R1 after release", dram_cmd, 0);

        // R2 R4 R8 R9: idle cadence, rows, cost total
        prev = 0;
        for (int k = 0; k < 10; k++) begin
            wait_ref(t);
            chk(dram_row == ROW_W'(k % 8), "R4/R8 refresh row", dram_row, k % 8);
            chk(next_row == ROW_W'(k % 8), "R8 next_row", next_row, k % 8);
            chk(refresh_cycles == 16'(REFC * k), "R9 cost total", refresh_cycles, REFC * k);
            if (k > 0) chk(t - prev == TICK, "R2 spacing", t - prev, TICK);
            if (k == 0) begin
                n = 0;
                for (int j = 0; j < 10; j++) begin
                    @(negedge clk);
                    #1;
                    if (array_busy) n++;
                end
                chk(n == REFC, "R7 refresh length", n, REFC);
            end
            prev = t;
        end
        repeat (REFC + 2) @(negedge clk);
        #1;
        chk(refresh_cycles == 16'(REFC * 10), "R9 after last", refresh_cycles, REFC * 10);

        // R5 R7: vector table of user accesses
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_write = VEC[v][7];
            req_row   = VEC[v][6:4];
            req_col   = VEC[v][3:0];
            #1;
            n = 0;
            while (!req_grant && n < 100) begin
                @(negedge clk);
                #1;
                n++;
            end
            chk(dram_cmd == (VEC[v][7] ? 2'd2 : 2'd1), "R5 cmd", dram_cmd, VEC[v][7] ? 2 : 1);
            chk(dram_row == VEC[v][6:4] && dram_col == VEC[v][3:0], "R5 address",
                {dram_row, dram_col}, VEC[v][6:0]);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            n = 0;
            while (array_busy && n < 20) begin
                @(negedge clk);
                #1;
                n++;
            end
            chk(n == ACCC, "R7 access length", n, ACCC);
        end

        // R6: request while a refresh is pending is held off
        n = 0;
        @(negedge clk);
        #1;
        while (pend_count == 0 && n < 200) begin
            @(negedge clk);
            #1;
            n++;
        end
        req_valid = 1'b1;
        req_write = 1'b0;
        req_row   = 3'd4;
        req_col   = 4'd9;
        #1;
        chk(!req_grant && dram_cmd == 2'd3, "R6 blocked by pending", req_grant, 0);
        tref = cyc;
        n = 0;
        while (!req_grant && n < 50) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(n == REFC + 1, "R6 grant after refresh", n, REFC + 1);
        @(negedge clk);
        req_valid = 1'b0;

        // R6: demand during an access waits for it to finish
        while (cyc < tref + TICK - 2) @(negedge clk);
        req_valid = 1'b1;
        #1;
        chk(req_grant == 1'b1, "R6 grant before demand", req_grant, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc < tref + TICK) @(negedge clk);
        #1;
        chk(pend_count == 1 && array_busy, "R6 pending during access", pend_count, 1);
        wait_ref(t);
        chk(t == tref + TICK + 2, "R6 deferred refresh cycle", t - tref, TICK + 2);

        // R3 R10: saturation in the fast-demand copy
        smax = 0;
        sgrant = 1'b0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            #1;
            if (int'(s_pend) > smax) smax = int'(s_pend);
            if (s_grant) sgrant = 1'b1;
        end
        chk(smax == MAXP, "R3 ceiling", smax, MAXP);
        chk(s_pend == PW'(MAXP), "R10 stays full", s_pend, MAXP);
        chk(!sgrant, "R10 no grant", sgrant, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule